// File: doc/BRIEF.md
# I2C Master Transfer Sequencer

This block runs one I2C master transfer, either a write or a read, one byte and one bus event at a time. A request gives a 7-bit target address, a direction, a byte count and a flag. The flag says whether the transfer ends with a stop or with a repeated start. The sequencer does not drive SCL or SDA. It commands a byte-level bus engine through one-cycle start, stop and write pulses, plus a level that enables automatic acknowledge. It follows that engine through five event inputs: start sent, address acknowledged, address not acknowledged, receive byte ready and byte transfer finished.

Transmit bytes come in through a ready/valid handshake. Received bytes go out with a valid strobe and their position in the transfer. For a read, automatic acknowledge is enabled before the data phase and dropped in time for the engine to NACK the final byte. Completion waits for the engine's byte-transfer-finished event, so the done pulse comes after the bus has really finished the last byte.

Top module: `i2c_xfer_seq`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), busy, tx_ready, eng_ack_en, all command pulses, rx_valid, done and the three error pulses are 0, and eng_wdata, rx_data and rx_index are 0.
- R2: A request (req_valid) seen while idle, and not rejected, pulses eng_start in the next cycle and raises busy. A request seen while busy has no effect.
- R3: When start-sent arrives while the sequencer waits for it, the next cycle pulses eng_wr with eng_wdata = {addr[6:0], rw}. The direction bit is in bit 0 and is 0 for a write and 1 for a read.
- R4: No data byte moves before address-acknowledged. If address-not-acknowledged arrives while the address is pending, the next cycle gives eng_stop and err_nack together, and the sequencer returns to idle.
- R5: In a write, tx_ready is high while a byte is awaited and no engine event is present. Each accepted byte pulses eng_wr with that byte on the next cycle. The sequencer then waits for byte-transfer-finished before it asks for the next byte.
- R6: In a read, each receive-byte-ready event gives, on the next cycle, rx_valid with rx_data = eng_rdata and rx_index = 0, 1, 2, ... in order.
- R7: eng_ack_en is set when a read of two or more bytes is requested. It drops on the cycle after the byte at index len-2 is taken. For a one-byte read it is never set.
- R8: The transfer completes only on byte-transfer-finished after the last byte has been sent or received. Completion gives done together with eng_stop when the flag is 0, or together with eng_start when it is 1, and busy drops.
- R9: Engine events that arrive while idle are ignored: they raise no error and produce no output.
- R10: An engine event that the current active state does not expect (several events at once count as unexpected unless all are expected) pulses err_unexp on the next cycle. It returns the sequencer to idle without any command, even if an expected event arrives in the same cycle.
- R11: A read request with length 0 pulses err_len on the next cycle and leaves the sequencer idle. A write with length 0 completes on the cycle after address-acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Transfer request, taken when idle |
| req_addr | input | 7 | Target address |
| req_read | input | 1 | 1 = read, 0 = write |
| req_len | input | LEN_W | Byte count |
| req_restart | input | 1 | 1 = end with repeated start, 0 = end with stop |
| busy | output | 1 | Transfer in progress |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | tx_data is valid |
| tx_ready | output | 1 | Sequencer accepts tx_data |
| rx_data | output | 8 | Received byte |
| rx_index | output | LEN_W | Position of rx_data in the transfer |
| rx_valid | output | 1 | rx_data/rx_index strobe |
| done | output | 1 | Transfer completed |
| err_unexp | output | 1 | Unexpected engine event, transfer dropped |
| err_nack | output | 1 | Address not acknowledged |
| err_len | output | 1 | Zero-length read rejected |
| eng_start | output | 1 | Start or repeated-start command pulse |
| eng_stop | output | 1 | Stop command pulse |
| eng_wr | output | 1 | Byte write command pulse |
| eng_wdata | output | 8 | Byte for eng_wr (address or data) |
| eng_ack_en | output | 1 | Engine acknowledges received bytes while high |
| eng_rdata | input | 8 | Byte from the engine with ev_rx_full |
| ev_start_done | input | 1 | Engine: start condition sent |
| ev_addr_ack | input | 1 | Engine: address acknowledged |
| ev_addr_nack | input | 1 | Engine: address not acknowledged |
| ev_rx_full | input | 1 | Engine: received byte ready |
| ev_xfer_done | input | 1 | Engine: byte transfer finished |

## Verification
Two things can land in the same cycle: the state's own expected event and a stray event that must abort the transfer. The bench provokes this by pulsing receive-byte-ready together with byte-transfer-finished in the middle of a read. It also pulses address-acknowledged and start-sent together while the address is pending. In both cases the abort must win: there is no rx strobe and no command, only err_unexp, and the sequencer goes idle. The second coincidence is the read of the next-to-last byte and the drop of automatic acknowledge. The reference model expects both on the same output cycle, and that is checked for two-byte and longer reads.

// File: rtl/i2cseq_pkg.sv
// Shared types for the I2C transfer sequencer.
// Assumes: one transfer at a time, events are single-cycle pulses.
package i2cseq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,  // no transfer, events ignored
        ST_ARM  = 3'd1,  // start requested, awaiting start-sent
        ST_ADDR = 3'd2,  // address byte written, awaiting ack/nack
        ST_TXF  = 3'd3,  // awaiting a transmit byte from the source
        ST_TXW  = 3'd4,  // data byte written, awaiting transfer finished
        ST_RX   = 3'd5,  // awaiting received bytes
        ST_FIN  = 3'd6   // last byte read, awaiting transfer finished
    } seq_st_t;

    typedef struct packed {
        logic start_done;
        logic addr_ack;
        logic addr_nack;
        logic rx_full;
        logic xfer_done;
    } seq_ev_t;
endpackage

// File: rtl/i2cseq_evchk.sv
// Event screen: flags engine events that the current state does not expect.
// Assumes: events in ST_IDLE are ignored by the caller, so none are flagged there.
module i2cseq_evchk
    import i2cseq_pkg::*;
(
    input  seq_st_t st,
    input  seq_ev_t ev,
    output logic    any_ev,
    output logic    unexp
);
    seq_ev_t allow;

    // Select the set of events the present state accepts.
    always_comb begin
        allow = '0;
        case (st)
            ST_ARM:         allow.start_done = 1'b1;
            ST_ADDR: begin
                allow.addr_ack  = 1'b1;
                allow.addr_nack = 1'b1;
            end
            ST_TXW, ST_FIN: allow.xfer_done = 1'b1;
            ST_RX:          allow.rx_full = 1'b1;
            default:        allow = '0;
        endcase
    end

    // Any event outside the accepted set counts as unexpected when active.
    always_comb begin
        any_ev = |ev;
        unexp  = (st != ST_IDLE) && (|(ev & ~allow));
    end
endmodule

// File: rtl/i2cseq_head.sv
// Byte position counter for one transfer, with end-of-transfer flags.
// Assumes: head never passes len; clr and inc are not asserted together.
module i2cseq_head #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [LEN_W-1:0] len,
    output logic [LEN_W-1:0] head,
    output logic             at_last,
    output logic             all_done,
    output logic             near_end
);
    localparam logic [LEN_W-1:0] TWO = LEN_W'(2);

    logic [LEN_W-1:0] left;

    // Count bytes moved since the transfer began.
    always_ff @(posedge clk) begin
        if (!rst_n)   head <= '0;
        else if (clr) head <= '0;
        else if (inc) head <= head + 1'b1;
    end

    // Derive remaining-byte flags from the head position.
    always_comb begin
        left     = len - head;
        at_last  = (head + 1'b1) == len;
        all_done = head == len;
        near_end = left <= TWO;
    end

    // R6
    head_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> (head == $past(head) + 1'b1));
endmodule

// File: rtl/i2c_xfer_seq.sv
// I2C master transfer sequencer: runs one write or read transfer through a
// byte-level bus engine using start/stop/write commands and engine events.
// Assumes: engine events are single-cycle pulses; a request is only taken
// when idle; a repeated start at the end leaves the bus to the next request.
module i2c_xfer_seq
    import i2cseq_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [6:0]       req_addr,
    input  logic             req_read,
    input  logic [LEN_W-1:0] req_len,
    input  logic             req_restart,
    output logic             busy,
    input  logic [7:0]       tx_data,
    input  logic             tx_valid,
    output logic             tx_ready,
    output logic [7:0]       rx_data,
    output logic [LEN_W-1:0] rx_index,
    output logic             rx_valid,
    output logic             done,
    output logic             err_unexp,
    output logic             err_nack,
    output logic             err_len,
    output logic             eng_start,
    output logic             eng_stop,
    output logic             eng_wr,
    output logic [7:0]       eng_wdata,
    output logic             eng_ack_en,
    input  logic [7:0]       eng_rdata,
    input  logic             ev_start_done,
    input  logic             ev_addr_ack,
    input  logic             ev_addr_nack,
    input  logic             ev_rx_full,
    input  logic             ev_xfer_done
);
    localparam logic [LEN_W-1:0] LEN_TWO = LEN_W'(2);

    seq_st_t          st;
    seq_ev_t          ev;
    logic             any_ev, unexp;
    logic [6:0]       addr_q;
    logic             rw_q, rs_q;
    logic [LEN_W-1:0] len_q, head;
    logic             at_last, all_done, near_end;
    logic             h_clr, h_inc;
    logic             tx_take;

    // Gather the engine events into one record.
    always_comb begin
        ev.start_done = ev_start_done;
        ev.addr_ack   = ev_addr_ack;
        ev.addr_nack  = ev_addr_nack;
        ev.rx_full    = ev_rx_full;
        ev.xfer_done  = ev_xfer_done;
    end

    i2cseq_evchk u_evchk (
        .st     (st),
        .ev     (ev),
        .any_ev (any_ev),
        .unexp  (unexp)
    );

    i2cseq_head #(.LEN_W(LEN_W)) u_head (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (h_clr),
        .inc      (h_inc),
        .len      (len_q),
        .head     (head),
        .at_last  (at_last),
        .all_done (all_done),
        .near_end (near_end)
    );

    // Handshake and counter controls that depend on the present state.
    always_comb begin
        busy     = st != ST_IDLE;
        tx_ready = (st == ST_TXF) && !any_ev;
        tx_take  = tx_ready && tx_valid;
        h_clr    = (st == ST_IDLE) && req_valid;
        h_inc    = tx_take || ((st == ST_RX) && ev_rx_full && !unexp);
    end

    // Main transfer state machine with registered command and status pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            addr_q     <= '0;
            rw_q       <= 1'b0;
            rs_q       <= 1'b0;
            len_q      <= '0;
            eng_start  <= 1'b0;
            eng_stop   <= 1'b0;
            eng_wr     <= 1'b0;
            eng_wdata  <= '0;
            eng_ack_en <= 1'b0;
            rx_valid   <= 1'b0;
            rx_data    <= '0;
            rx_index   <= '0;
            done       <= 1'b0;
            err_unexp  <= 1'b0;
            err_nack   <= 1'b0;
            err_len    <= 1'b0;
        end else begin
            eng_start <= 1'b0;
            eng_stop  <= 1'b0;
            eng_wr    <= 1'b0;
            rx_valid  <= 1'b0;
            done      <= 1'b0;
            err_unexp <= 1'b0;
            err_nack  <= 1'b0;
            err_len   <= 1'b0;
            if (unexp) begin
                err_unexp  <= 1'b1;
                eng_ack_en <= 1'b0;
                st         <= ST_IDLE;
            end else begin
                case (st)
                    ST_IDLE: if (req_valid) begin
                        if (req_read && req_len == '0) begin
                            err_len <= 1'b1;
                        end else begin
                            addr_q     <= req_addr;
                            rw_q       <= req_read;
                            rs_q       <= req_restart;
                            len_q      <= req_len;
                            eng_start  <= 1'b1;
                            eng_ack_en <= req_read && (req_len >= LEN_TWO);
                            st         <= ST_ARM;
                        end
                    end
                    ST_ARM: if (ev_start_done) begin
                        eng_wr    <= 1'b1;
                        eng_wdata <= {addr_q, rw_q};
                        st        <= ST_ADDR;
                    end
                    ST_ADDR: begin
                        if (ev_addr_nack) begin
                            eng_stop   <= 1'b1;
                            err_nack   <= 1'b1;
                            eng_ack_en <= 1'b0;
                            st         <= ST_IDLE;
                        end else if (ev_addr_ack) begin
                            if (rw_q) begin
                                st <= ST_RX;
                            end else if (all_done) begin
                                done      <= 1'b1;
                                eng_start <= rs_q;
                                eng_stop  <= !rs_q;
                                st        <= ST_IDLE;
                            end else begin
                                st <= ST_TXF;
                            end
                        end
                    end
                    ST_TXF: if (tx_take) begin
                        eng_wr    <= 1'b1;
                        eng_wdata <= tx_data;
                        st        <= ST_TXW;
                    end
                    ST_TXW: if (ev_xfer_done) begin
                        if (all_done) begin
                            done      <= 1'b1;
                            eng_start <= rs_q;
                            eng_stop  <= !rs_q;
                            st        <= ST_IDLE;
                        end else begin
                            st <= ST_TXF;
                        end
                    end
                    ST_RX: if (ev_rx_full) begin
                        rx_valid <= 1'b1;
                        rx_data  <= eng_rdata;
                        rx_index <= head;
                        if (near_end) eng_ack_en <= 1'b0;
                        if (at_last)  st <= ST_FIN;
                    end
                    ST_FIN: if (ev_xfer_done) begin
                        done       <= 1'b1;
                        eng_start  <= rs_q;
                        eng_stop   <= !rs_q;
                        eng_ack_en <= 1'b0;
                        st         <= ST_IDLE;
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R4
    nack_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_nack |-> (eng_stop && !busy));
    // R6
    rx_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(ev_rx_full));
    // R7
    ack_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_ack_en) |-> $past(!busy && req_valid && req_read));
    // R3
    one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({eng_start, eng_stop, eng_wr}));
    // R10
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_unexp |-> (!busy && !eng_start && !eng_stop && !eng_wr && !rx_valid));
endmodule

// File: tb/sim_i2c_xfer_seq.sv
// Bench: behavioural reference model compared with the design on every clock.
module sim_i2c_xfer_seq;
    localparam int LW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_read = 0, req_restart = 0;
    logic [6:0] req_addr = 0;
    logic [LW-1:0] req_len = 0;
    logic [7:0] tx_data = 0, eng_rdata = 0;
    logic tx_valid = 0;
    logic ev_start_done = 0, ev_addr_ack = 0, ev_addr_nack = 0, ev_rx_full = 0, ev_xfer_done = 0;
    logic busy, tx_ready, rx_valid, done, err_unexp, err_nack, err_len;
    logic eng_start, eng_stop, eng_wr, eng_ack_en;
    logic [7:0] rx_data, eng_wdata;
    logic [LW-1:0] rx_index;

    always #2.5 clk = ~clk;

    i2c_xfer_seq #(.LEN_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_read(req_read), .req_len(req_len), .req_restart(req_restart),
        .busy(busy), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_index(rx_index), .rx_valid(rx_valid), .done(done),
        .err_unexp(err_unexp), .err_nack(err_nack), .err_len(err_len),
        .eng_start(eng_start), .eng_stop(eng_stop), .eng_wr(eng_wr),
        .eng_wdata(eng_wdata), .eng_ack_en(eng_ack_en), .eng_rdata(eng_rdata),
        .ev_start_done(ev_start_done), .ev_addr_ack(ev_addr_ack),
        .ev_addr_nack(ev_addr_nack), .ev_rx_full(ev_rx_full), .ev_xfer_done(ev_xfer_done)
    );

    int n_chk = 0, n_bad = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model state: phase 0 idle, 1 wait start, 2 wait addr reply,
    // 3 want tx byte, 4 wait byte done, 5 reading, 6 wait final byte done.
    int ph = 0, pos = 0, cnt = 0;
    bit m_rw = 0, m_rs = 0;
    int m_addr = 0;
    bit m_start = 0, m_stop = 0, m_wr = 0, m_ack = 0, m_rxv = 0, m_done = 0;
    bit m_eu = 0, m_en = 0, m_el = 0;
    int m_wd = 0, m_rd = 0, m_ri = 0;

    function automatic bit allowed(int p);
        case (p)
            1: return !(ev_addr_ack | ev_addr_nack | ev_rx_full | ev_xfer_done);
            2: return !(ev_start_done | ev_rx_full | ev_xfer_done);
            3: return !(ev_start_done | ev_addr_ack | ev_addr_nack | ev_rx_full | ev_xfer_done);
            4, 6: return !(ev_start_done | ev_addr_ack | ev_addr_nack | ev_rx_full);
            5: return !(ev_start_done | ev_addr_ack | ev_addr_nack | ev_xfer_done);
            default: return 1'b1;
        endcase
    endfunction

    task automatic m_finish();
        m_done = 1; m_start = m_rs; m_stop = !m_rs; m_ack = 0; ph = 0;
    endtask

    always @(posedge clk) begin
        m_start = 0; m_stop = 0; m_wr = 0; m_rxv = 0; m_done = 0;
        m_eu = 0; m_en = 0; m_el = 0;
        if (!rst_n) begin
            ph = 0; pos = 0; cnt = 0; m_ack = 0; m_wd = 0; m_rd = 0; m_ri = 0;
        end else if (ph != 0 && !allowed(ph)) begin
            m_eu = 1; m_ack = 0; ph = 0;
        end else begin
            case (ph)
                0: if (req_valid) begin
                    if (req_read && req_len == 0) m_el = 1;
                    else begin
                        m_addr = req_addr; m_rw = req_read; m_rs = req_restart;
                        cnt = req_len; pos = 0; m_start = 1;
                        m_ack = req_read && req_len >= 2; ph = 1;
                    end
                end
                1: if (ev_start_done) begin m_wr = 1; m_wd = m_addr * 2 + m_rw; ph = 2; end
                2: if (ev_addr_nack) begin m_stop = 1; m_en = 1; m_ack = 0; ph = 0; end
                   else if (ev_addr_ack) begin
                       if (m_rw) ph = 5;
                       else if (cnt == 0) m_finish();
                       else ph = 3;
                   end
                3: if (tx_valid) begin m_wr = 1; m_wd = tx_data; pos++; ph = 4; end
                4: if (ev_xfer_done) begin if (pos == cnt) m_finish(); else ph = 3; end
                5: if (ev_rx_full) begin
                    m_rxv = 1; m_rd = eng_rdata; m_ri = pos;
                    if (cnt - pos <= 2) m_ack = 0;
                    pos++;
                    if (pos == cnt) ph = 6;
                end
                6: if (ev_xfer_done) m_finish();
                default: ph = 0;
            endcase
        end
    end

    // Compare every output with the model just after each edge.
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            chk(busy == (ph != 0), "R2 busy", busy, ph != 0);
            chk(tx_ready == (ph == 3 && allowed(3)), "R5 tx_ready", tx_ready, ph == 3);
            chk(eng_start == m_start, "R2/R8 eng_start", eng_start, m_start);
            chk(eng_stop == m_stop, "R8 eng_stop", eng_stop, m_stop);
            chk(eng_wr == m_wr, "R3 eng_wr", eng_wr, m_wr);
            chk(int'(eng_wdata) == m_wd, "R3 eng_wdata", eng_wdata, m_wd);
            chk(eng_ack_en == m_ack, "R7 eng_ack_en", eng_ack_en, m_ack);
            chk(rx_valid == m_rxv, "R6 rx_valid", rx_valid, m_rxv);
            chk(int'(rx_data) == m_rd && int'(rx_index) == m_ri, "R6 rx_data/index",
                {rx_index, rx_data}, m_ri * 256 + m_rd);
            chk(done == m_done, "R8 done", done, m_done);
            chk(err_unexp == m_eu, "R10 err_unexp", err_unexp, m_eu);
            chk(err_nack == m_en, "R4 err_nack", err_nack, m_en);
            chk(err_len == m_el, "R11 err_len", err_len, m_el);
        end
    end

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic req(int a, bit rd, int len, bit rs);
        req_valid = 1; req_addr = 7'(a); req_read = rd; req_len = LW'(len); req_restart = rs;
        tick();
        req_valid = 0;
    endtask

    // Pulse a set of events {start, ack, nack, rxfull, xfer} for one cycle.
    task automatic evp(logic [4:0] e, logic [7:0] d = 8'h00);
        {ev_start_done, ev_addr_ack, ev_addr_nack, ev_rx_full, ev_xfer_done} = e;
        eng_rdata = d;
        tick();
        {ev_start_done, ev_addr_ack, ev_addr_nack, ev_rx_full, ev_xfer_done} = '0;
    endtask

    task automatic send_byte(logic [7:0] b);
        tx_valid = 1; tx_data = b; tick(); tx_valid = 0; tick();
        evp(5'b00001); tick();
    endtask

    task automatic read_xfer(int a, int len, bit rs);
        req(a, 1, len, rs); tick();
        evp(5'b10000); tick();
        evp(5'b01000); tick();
        for (int i = 0; i < len; i++) begin evp(5'b00010, 8'(8'h50 + i)); tick(); end
        evp(5'b00001); tick(2);
    endtask

    initial begin
        #200000;
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        tick(3);
        // R1: reset values at the ports
        chk(!busy && !tx_ready && !eng_ack_en && !eng_start && !eng_stop && !eng_wr &&
            !rx_valid && !done && !err_unexp && !err_nack && !err_len &&
            eng_wdata == 0 && rx_data == 0 && rx_index == 0, "R1 reset", busy, 0);
        rst_n = 1; tick(2);

        // R9: events while idle are ignored
        evp(5'b11111, 8'hEE); tick();
        chk(!busy && !err_unexp && !rx_valid, "R9 idle events", err_unexp, 0);

        // R3 R5 R8: write of three bytes ending with stop, plus a request while busy
        req(7'h2A, 0, 3, 0);
        req(7'h11, 1, 4, 1);   // R2: ignored, transfer already armed
        evp(5'b10000); tick();
        evp(5'b01000); tick();
        send_byte(8'hC3); send_byte(8'h00); send_byte(8'hFF); tick();

        // R6 R7 R8: reads of four, two and one bytes
        read_xfer(7'h55, 4, 1);
        read_xfer(7'h7F, 2, 0);
        read_xfer(7'h01, 1, 0);

        // R11: zero-length read rejected, zero-length write completes after ack
        req(7'h33, 1, 0, 0); tick();
        chk(!busy, "R11 zero read stays idle", busy, 0);
        req(7'h33, 0, 0, 1); tick();
        evp(5'b10000); tick();
        evp(5'b01000); tick(2);

        // R4: address NACK aborts with stop
        req(7'h40, 1, 3, 0); tick();
        evp(5'b10000); tick();
        evp(5'b00100); tick(2);

        // R10: expected and unexpected event together while reading
        req(7'h12, 1, 3, 0); tick();
        evp(5'b10000); tick();
        evp(5'b01000); tick();
        evp(5'b00010, 8'h9A); tick();
        evp(5'b00011, 8'h9B); tick(2);
        chk(!busy, "R10 back to idle", busy, 0);

        // R10: ack together with start-sent while the address is pending
        req(7'h21, 0, 2, 0); tick();
        evp(5'b10000); tick();
        evp(5'b11000); tick(2);

        // R4: no data before ack; stray data event while waiting is an error
        req(7'h22, 0, 1, 0); tick();
        evp(5'b10000); tick();
        chk(!tx_ready, "R4 no data before ack", tx_ready, 0);
        evp(5'b00001); tick(2);

        // R5: write with delayed source, ending with repeated start
        req(7'h03, 0, 2, 1); tick();
        evp(5'b10000); tick();
        evp(5'b01000); tick(3);
        send_byte(8'h5A); tick(2); send_byte(8'hA5); tick(2);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule